// File: doc/BRIEF.md
# Triplicated Register with Voted Feedback

This block is a WIDTH-bit state register protected by triple modular redundancy. It holds three independent copies of the storage. Each copy has its own clock, its own enable, its own data input, its own next-state logic and its own bitwise majority voter. The voter of each copy looks at all three stored values. That voted value is both the copy's output and the feedback from which the copy computes its next state. A single corrupted copy therefore never reaches any output, and it is overwritten with the majority value at its next clock edge.

The flip-flops have no enable. When a copy's enable is low, a 2:1 selector in front of the copy reloads the voted value. Every copy is therefore rewritten on every clock, so an upset is repaired even while the register is only holding. A parameter picks the next-state function. In load mode an enabled copy takes its data input. In count mode an enabled copy takes the voted value plus one, as a program counter does. A combinational disagreement flag shows when the three stored copies differ. It exists so that a testbench can see the fault and its repair.

Top module: `tmr_reg`

## Requirements
- R1: A clock edge with rst_n low clears all three copies, and it takes priority over the enables. Afterwards q1, q2 and q3 read 0 and mismatch reads 0.
- R2: In load mode (MODE = NEXT_LOAD), an edge with rst_n high and all three enables at 1 stores each copy's own data input. With d1 = d2 = d3 = D, all three outputs read D after that edge.
- R3: An edge with rst_n high and all three enables at 0 leaves q1, q2 and q3 unchanged.
- R4: Every bit of every output is the majority of that bit in the three stored copies: it is 1 when at least two copies hold 1. When a single copy holds a different value, all three outputs keep the value the other two copies agree on.
- R5: A copy whose enable is 0 stores its voted value at its next edge. A lone divergent copy is therefore repaired one edge after it appeared, even with every enable at 0.
- R6: mismatch is 1 exactly when the three stored copies are not all equal.
- R7: In count mode (MODE = NEXT_COUNT), an enabled copy stores its voted value plus one, and the data inputs have no effect.
- R8: In count mode the increment wraps modulo 2^WIDTH. From all ones, one enabled edge gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk1 | input | 1 | Clock of copy 1 |
| clk2 | input | 1 | Clock of copy 2 |
| clk3 | input | 1 | Clock of copy 3 |
| rst_n | input | 1 | Synchronous active-low clear of all copies |
| en1 | input | 1 | Update enable of copy 1 |
| en2 | input | 1 | Update enable of copy 2 |
| en3 | input | 1 | Update enable of copy 3 |
| d1 | input | WIDTH | Load data of copy 1 |
| d2 | input | WIDTH | Load data of copy 2 |
| d3 | input | WIDTH | Load data of copy 3 |
| q1 | output | WIDTH | Voted output of copy 1 |
| q2 | output | WIDTH | Voted output of copy 2 |
| q3 | output | WIDTH | Voted output of copy 3 |
| mismatch | output | 1 | High while the stored copies disagree |

## Verification
The bench faults a copy through its normal ports: it raises one copy's enable alone with a different value. Stored values change only at a clock edge, and the voters and the mismatch flag follow them combinationally. So every result of a stimulus applied before edge k is due right after edge k. The repair of a faulted copy is due after edge k+1. The bench drives inputs at the falling edge, advances a behavioural model of the three copies at the rising edge, and compares every output of both mode instances at the next falling edge, one cycle at a time.

// File: rtl/tmr_reg_pkg.sv
// Package tmr_reg_pkg
// Shared types of the triplicated register: the choice of next-state
// function and the number of redundant copies.
package tmr_reg_pkg;

    // Next-state function used by an enabled copy
    typedef enum logic {
        NEXT_LOAD  = 1'b0,  // take the copy's data input
        NEXT_COUNT = 1'b1   // take the voted value plus one
    } next_mode_e;

    localparam int unsigned COPIES = 3;

endpackage

// File: rtl/tmr_majority.sv
// Module tmr_majority
// Bitwise two-out-of-three majority of three words. Purely combinational.
// Assumes the three inputs are the stored copies of one register.
module tmr_majority #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    input  logic [WIDTH-1:0] in_c,
    output logic [WIDTH-1:0] voted
);

    // One small majority gate for each bit position
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign voted[b] = (in_a[b] & in_b[b]) | (in_a[b] & in_c[b]) | (in_b[b] & in_c[b]);
    end

endmodule

// File: rtl/tmr_next.sv
// Module tmr_next
// Next-state selection of one copy. A low enable reloads the voted value,
// so the flip-flop behind it can be written on every clock. MODE selects
// whether an enabled copy loads data or increments the voted value.
// Assumes that voted is the copy's own majority output.
module tmr_next
    import tmr_reg_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter next_mode_e  MODE  = NEXT_LOAD
) (
    input  logic             en,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] voted,
    output logic [WIDTH-1:0] next_val
);

    if (MODE == NEXT_COUNT) begin : g_count
        logic [WIDTH-1:0] unused_data;
        // Keep the data input tied off; counting ignores it
        assign unused_data = data;
        // Enabled: voted plus one, wrapping; otherwise reload the voted value
        always_comb next_val = en ? voted + {{(WIDTH-1){1'b0}}, 1'b1} : voted;
    end else begin : g_load
        // Enabled: new data; otherwise reload the voted value
        always_comb next_val = en ? data : voted;
    end

endmodule

// File: rtl/tmr_lane.sv
// Module tmr_lane
// One redundant copy: its own voter, its own next-state selector and its
// own storage, on its own clock. The flip-flop has no enable and is
// written on every edge. Assumes that the stored values of all three
// copies arrive on st_a, st_b and st_c.
module tmr_lane
    import tmr_reg_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter next_mode_e  MODE  = NEXT_LOAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] data,
    input  logic [WIDTH-1:0] st_a,
    input  logic [WIDTH-1:0] st_b,
    input  logic [WIDTH-1:0] st_c,
    output logic [WIDTH-1:0] voted,
    output logic [WIDTH-1:0] state
);

    logic [WIDTH-1:0] next_val;

    tmr_majority #(.WIDTH(WIDTH)) i_vote (
        .in_a (st_a),
        .in_b (st_b),
        .in_c (st_c),
        .voted(voted)
    );

    tmr_next #(.WIDTH(WIDTH), .MODE(MODE)) i_next (
        .en      (en),
        .data    (data),
        .voted   (voted),
        .next_val(next_val)
    );

    // Storage of this copy: cleared by reset, otherwise loaded every edge
    always_ff @(posedge clk) begin
        if (!rst_n) state <= '0;
        else        state <= next_val;
    end

    // Checker state: reset was low at the previous edge
    logic rst_was_low = 1'b0;
    always_ff @(posedge clk) rst_was_low <= !rst_n;

    // R1
    reset_clears_chk: assert property (@(posedge clk) rst_was_low |-> state == '0);

    // R5
    idle_reloads_vote_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == $past(voted));

endmodule

// File: rtl/tmr_reg.sv
// Module tmr_reg
// Triplicated register with voted feedback. Three copies, each with its
// own clock, enable, data and voted output. Every copy computes its next
// state from the majority of all three stored copies, so a single upset
// never reaches an output and is repaired at the next edge. mismatch is
// for observation only. Assumes that the three clocks are nominally equal.
module tmr_reg
    import tmr_reg_pkg::*;
#(
    parameter int unsigned WIDTH = 8,
    parameter next_mode_e  MODE  = NEXT_LOAD
) (
    input  logic             clk1,
    input  logic             clk2,
    input  logic             clk3,
    input  logic             rst_n,
    input  logic             en1,
    input  logic             en2,
    input  logic             en3,
    input  logic [WIDTH-1:0] d1,
    input  logic [WIDTH-1:0] d2,
    input  logic [WIDTH-1:0] d3,
    output logic [WIDTH-1:0] q1,
    output logic [WIDTH-1:0] q2,
    output logic [WIDTH-1:0] q3,
    output logic             mismatch
);

    localparam int unsigned N = COPIES;

    logic             clk_v [N];
    logic             en_v  [N];
    logic [WIDTH-1:0] d_v   [N];
    logic [WIDTH-1:0] q_v   [N];
    logic [WIDTH-1:0] st_v  [N];

    // Gather the per-copy ports into arrays
    assign clk_v[0] = clk1;
    assign clk_v[1] = clk2;
    assign clk_v[2] = clk3;
    assign en_v[0]  = en1;
    assign en_v[1]  = en2;
    assign en_v[2]  = en3;
    assign d_v[0]   = d1;
    assign d_v[1]   = d2;
    assign d_v[2]   = d3;

    // One lane per copy, each voting over all three stored values
    for (genvar k = 0; k < N; k++) begin : g_lane
        tmr_lane #(.WIDTH(WIDTH), .MODE(MODE)) i_lane (
            .clk  (clk_v[k]),
            .rst_n(rst_n),
            .en   (en_v[k]),
            .data (d_v[k]),
            .st_a (st_v[0]),
            .st_b (st_v[1]),
            .st_c (st_v[2]),
            .voted(q_v[k]),
            .state(st_v[k])
        );
    end

    assign q1 = q_v[0];
    assign q2 = q_v[1];
    assign q3 = q_v[2];

    // Disagreement among the stored copies
    always_comb mismatch = (st_v[0] != st_v[1]) || (st_v[1] != st_v[2]);

    // R4
    outputs_agree_chk: assert property (@(posedge clk1) disable iff (!rst_n)
        (q1 == q2) && (q2 == q3));

    // R5
    fault_repaired_chk: assert property (@(posedge clk1) disable iff (!rst_n)
        (mismatch && !en1 && !en2 && !en3) |=> !mismatch);

    // R3
    idle_holds_chk: assert property (@(posedge clk1) disable iff (!rst_n)
        (!en1 && !en2 && !en3) |=> $stable(q1));

    if (MODE == NEXT_COUNT) begin : g_count_chk
        // R7
        count_step_chk: assert property (@(posedge clk1) disable iff (!rst_n)
            (en1 && en2 && en3) |=> q1 == WIDTH'($past(q1) + 1'b1));
    end else begin : g_load_chk
        // R2
        load_value_chk: assert property (@(posedge clk1) disable iff (!rst_n)
            (en1 && en2 && en3 && d1 == d2 && d2 == d3) |=> q1 == $past(d1));
    end

endmodule

// File: tb/test_tmr_reg.sv
module test_tmr_reg;
    import tmr_reg_pkg::*;

    localparam int unsigned W          = 8;
    localparam int          CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en1 = 1'b0, en2 = 1'b0, en3 = 1'b0;
    logic [W-1:0] d1 = '0, d2 = '0, d3 = '0;
    logic [W-1:0] lq1, lq2, lq3, cq1, cq2, cq3;
    logic         lmis, cmis;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    // Behavioural model of the stored copies: load and count instances
    logic [W-1:0] ml[3];
    logic [W-1:0] mc[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_reg #(.WIDTH(W), .MODE(NEXT_LOAD)) i_tmr_reg (
        .clk1(clk), .clk2(clk), .clk3(clk), .rst_n(rst_n),
        .en1(en1), .en2(en2), .en3(en3), .d1(d1), .d2(d2), .d3(d3),
        .q1(lq1), .q2(lq2), .q3(lq3), .mismatch(lmis));

    tmr_reg #(.WIDTH(W), .MODE(NEXT_COUNT)) i_tmr_reg_cnt (
        .clk1(clk), .clk2(clk), .clk3(clk), .rst_n(rst_n),
        .en1(en1), .en2(en2), .en3(en3), .d1(d1), .d2(d2), .d3(d3),
        .q1(cq1), .q2(cq2), .q3(cq3), .mismatch(cmis));

    function automatic logic [W-1:0] majority(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [W-1:0] y;
        for (int i = 0; i < W; i++) begin
            int ones = int'(a[i]) + int'(b[i]) + int'(c[i]);
            y[i] = (ones >= 2);
        end
        return y;
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance the model at the rising edge, compare at the falling edge
    task automatic cycle(string tag);
        logic [W-1:0] vl, vc;
        logic         en[3];
        logic [W-1:0] dv[3];
        @(posedge clk);
        en = '{en1, en2, en3};
        dv = '{d1, d2, d3};
        vl = majority(ml[0], ml[1], ml[2]);
        vc = majority(mc[0], mc[1], mc[2]);
        for (int k = 0; k < 3; k++) begin
            ml[k] = !rst_n ? '0 : en[k] ? dv[k] : vl;
            mc[k] = !rst_n ? '0 : en[k] ? W'(vc + 1) : vc;
        end
        @(negedge clk);
        vl = majority(ml[0], ml[1], ml[2]);
        vc = majority(mc[0], mc[1], mc[2]);
        check({tag, " load q1"}, lq1, vl);
        check({tag, " load q2"}, lq2, vl);
        check({tag, " load q3"}, lq3, vl);
        check({tag, " load mismatch"}, W'(lmis), W'(ml[0] != ml[1] || ml[1] != ml[2]));
        check({tag, " count q1"}, cq1, vc);
        check({tag, " count q2"}, cq2, vc);
        check({tag, " count q3"}, cq3, vc);
        check({tag, " count mismatch"}, W'(cmis), W'(mc[0] != mc[1] || mc[1] != mc[2]));
    endtask

    task automatic drive(logic r, logic e1, logic e2, logic e3,
                         logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        rst_n = r; en1 = e1; en2 = e2; en3 = e3; d1 = a; d2 = b; d3 = c;
    endtask

    // Fault one copy (k) by enabling it alone with a value, then repair
    task automatic fault_and_repair(int k, logic [W-1:0] bad_val);
        logic [W-1:0] lbefore, cbefore;
        lbefore = lq1; cbefore = cq1;
        drive(1, k == 0, k == 1, k == 2, bad_val, bad_val, bad_val);
        cycle("R4");
        check("R4 load output kept", lq2, lbefore);
        check("R4 count output kept", cq3, cbefore);
        check("R6 load mismatch up", W'(lmis), W'(1));
        check("R6 count mismatch up", W'(cmis), W'(1));
        drive(1, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        cycle("R5");
        check("R5 load repaired", W'(lmis), W'(0));
        check("R5 count repaired", W'(cmis), W'(0));
        check("R3 load held", lq1, lbefore);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset
        drive(0, 0, 0, 0, 8'h00, 8'h00, 8'h00);
        cycle("R1");
        cycle("R1");
        check("R1 load cleared", lq1, 8'h00);
        check("R1 count cleared", cq2, 8'h00);

        // R2 load, R7 count step
        drive(1, 1, 1, 1, 8'hA5, 8'hA5, 8'hA5);
        cycle("R2");
        check("R2 load value", lq3, 8'hA5);
        check("R7 count one", cq1, 8'h01);
        // R3 hold
        drive(1, 0, 0, 0, 8'h3C, 8'h3C, 8'h3C);
        for (int i = 0; i < 3; i++) cycle("R3");
        check("R3 load hold", lq1, 8'hA5);
        check("R7 data ignored", cq1, 8'h01);

        // R4 R5 R6: single-copy faults in each copy
        fault_and_repair(1, 8'h5A);
        fault_and_repair(0, 8'hFF);
        fault_and_repair(2, 8'h00);

        // Mixed stimulus, never more than one copy faulted at once
        for (int n = 0; n < 400; n++) begin
            int pick = $urandom_range(0, 3);
            logic [W-1:0] v = W'($urandom);
            if (pick == 0)      drive(1, 1, 1, 1, v, v, v);
            else if (pick == 1) drive(1, 0, 0, 0, v, v, v);
            else if (pick == 2) begin
                int k = $urandom_range(0, 2);
                drive(1, k == 0, k == 1, k == 2, v, v, v);
            end else drive(n % 50 != 7, 1, 1, 1, v, v, v);
            cycle("R4 R6 mixed");
        end

        // R8: wrap of the counter
        drive(0, 1, 1, 1, 8'h77, 8'h77, 8'h77);
        cycle("R1 priority");
        check("R1 reset over enable", lq1, 8'h00);
        drive(1, 1, 1, 1, 8'h77, 8'h77, 8'h77);
        for (int i = 0; i < 255; i++) cycle("R7");
        check("R8 count all ones", cq2, 8'hFF);
        cycle("R8");
        check("R8 count wrapped", cq2, 8'h00);
        check("R2 load equal data", lq2, 8'h77);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule